// File: doc/BRIEF.md
# Display Memory Write Pointer

This block holds the write position into a graphic display memory laid out as 84 columns by 6 byte-rows, which gives 504 bytes. The position has two parts: a 7-bit column index and a 3-bit bank index. A command path can load each part on its own. A data path writes bytes into the memory at the current position. After every accepted byte the position steps to the next cell, and a scan-order flag chooses the order. In horizontal order the column moves first and carries into the bank. In vertical order the bank moves first and carries into the column. In both orders, a write at the last cell sends the pointer back to the origin.

The block also includes the 504-byte memory itself, as a synchronous array that maps to block RAM. It has a registered read port for the refresh side, and it exposes the linear address that each write uses. The surrounding command decoder drives the load strobes. The serial receiver drives the byte-write strobe.

Top module: `disp_wr_pointer`

## Requirements
- R1: A synchronous active-high `rst` sets column 0, bank 0 and horizontal order (`scan_mode` = 0) at the next rising edge.
- R2: The column output never exceeds 83 and the bank output never exceeds 5.
- R3: In horizontal order (`scan_mode` = 0) a write increments the column. From column 83 it returns to column 0 and the bank increments.
- R4: In vertical order (`scan_mode` = 1) a write increments the bank. From bank 5 it returns to bank 0 and the column increments.
- R5: A write at column 83, bank 5 returns the pointer to column 0, bank 0 in either order.
- R6: `col_ld` loads the column from `col_val` and leaves the bank unchanged. A value above 83 is loaded as 83.
- R7: `bank_ld` loads the bank from `bank_val` and leaves the column unchanged. A value above 5 is loaded as 5.
- R8: When a load and a write fall in the same cycle, the loaded part takes the load value. The other part takes its advanced value.
- R9: `mode_ld` sets the order from `mode_val` and does not move the pointer. A write in the same cycle still uses the previous order.
- R10: `lin_addr` equals bank*84 + column of the current pointer, with no register delay.
- R11: A write stores `wr_data` at the linear address that held before the advance. `rd_data` returns the byte at `rd_addr` one cycle after `rd_addr` is presented.
- R12: `mem_we` is high exactly when `wr_en` is high and `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_ld | input | 1 | Load strobe for the column |
| col_val | input | 7 | Column load value |
| bank_ld | input | 1 | Load strobe for the bank |
| bank_val | input | 3 | Bank load value |
| mode_ld | input | 1 | Load strobe for the scan order |
| mode_val | input | 1 | Scan order: 0 horizontal, 1 vertical |
| wr_en | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte |
| rd_addr | input | 9 | Refresh read address |
| rd_data | output | 8 | Refresh read data, one cycle latency |
| cur_col | output | 7 | Current column |
| cur_bank | output | 3 | Current bank |
| scan_mode | output | 1 | Current scan order |
| lin_addr | output | 9 | Linear address of the current pointer |
| mem_we | output | 1 | Write enable into the memory |

## Verification
The assertions check on every cycle that the pointer stays in range and holds still when nothing acts on it. They also check the single-step carry in each order, the wrap from the last cell to the origin, load clamping, and the reset values. Only the bench's scenarios can show the rest. This covers the complete 504-step traversal in both orders, the content each traversal leaves in memory as seen through the read port, and the priority between loads and a write in the same cycle. It also covers the rule that a change of order reaches only later writes.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  typedef enum logic {
    SCAN_HORIZ = 1'b0,
    SCAN_VERT  = 1'b1
  } scan_mode_e;

endpackage

// File: rtl/dptr_next.sv
module dptr_next
  import dptr_pkg::*;
#(
  parameter int unsigned COLS  = 84,
  parameter int unsigned BANKS = 6,
  parameter int unsigned CW    = $clog2(COLS),
  parameter int unsigned BW    = $clog2(BANKS)
) (
  input  logic [CW-1:0] col,
  input  logic [BW-1:0] bank,
  input  scan_mode_e    mode,
  output logic [CW-1:0] nxt_col,
  output logic [BW-1:0] nxt_bank
);

  localparam logic [CW-1:0] LAST_C = CW'(COLS - 1);
  localparam logic [BW-1:0] LAST_B = BW'(BANKS - 1);

  logic          col_end;
  logic          bank_end;
  logic [CW-1:0] col_step;
  logic [BW-1:0] bank_step;

  assign col_end   = (col == LAST_C);
  assign bank_end  = (bank == LAST_B);
  assign col_step  = col_end ? '0 : col + 1'b1;
  assign bank_step = bank_end ? '0 : bank + 1'b1;

  always_comb begin
    if (mode == SCAN_HORIZ) begin
      nxt_col  = col_step;
      nxt_bank = col_end ? bank_step : bank;
    end else begin
      nxt_bank = bank_step;
      nxt_col  = bank_end ? col_step : col;
    end
  end

endmodule

// File: rtl/dptr_regs.sv
module dptr_regs
  import dptr_pkg::*;
#(
  parameter int unsigned COLS  = 84,
  parameter int unsigned BANKS = 6,
  parameter int unsigned CW    = $clog2(COLS),
  parameter int unsigned BW    = $clog2(BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] nxt_col,
  input  logic [BW-1:0] nxt_bank,
  input  logic          col_ld,
  input  logic [CW-1:0] col_val,
  input  logic          bank_ld,
  input  logic [BW-1:0] bank_val,
  input  logic          mode_ld,
  input  scan_mode_e    mode_val,
  output logic [CW-1:0] col,
  output logic [BW-1:0] bank,
  output scan_mode_e    mode
);

  localparam logic [CW-1:0] LAST_C = CW'(COLS - 1);
  localparam logic [BW-1:0] LAST_B = BW'(BANKS - 1);

  logic [CW-1:0] col_cl;
  logic [BW-1:0] bank_cl;

  assign col_cl  = (col_val > LAST_C) ? LAST_C : col_val;
  assign bank_cl = (bank_val > LAST_B) ? LAST_B : bank_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      bank <= '0;
      mode <= SCAN_HORIZ;
    end else begin
      if (col_ld)       col <= col_cl;
      else if (adv)     col <= nxt_col;
      if (bank_ld)      bank <= bank_cl;
      else if (adv)     bank <= nxt_bank;
      if (mode_ld)      mode <= mode_val;
    end
  end

  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (col == '0 && bank == '0 && mode == SCAN_HORIZ));

  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    (col <= LAST_C && bank <= LAST_B));

  p_hstep_r3: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == SCAN_HORIZ && !col_ld && !bank_ld && col != LAST_C)
    |=> (col == CW'($past(col) + 1'b1) && bank == $past(bank)));

  p_vstep_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == SCAN_VERT && !col_ld && !bank_ld && bank != LAST_B)
    |=> (bank == BW'($past(bank) + 1'b1) && col == $past(col)));

  p_origin_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && !col_ld && !bank_ld && col == LAST_C && bank == LAST_B)
    |=> (col == '0 && bank == '0));

  p_col_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (col_ld && col_val > LAST_C) |=> (col == LAST_C));

  p_bank_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (bank_ld && bank_val > LAST_B) |=> (bank == LAST_B));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!adv && !col_ld && !bank_ld) |=> ($stable(col) && $stable(bank)));

endmodule

// File: rtl/dptr_linear.sv
module dptr_linear #(
  parameter int unsigned COLS  = 84,
  parameter int unsigned BANKS = 6,
  parameter int unsigned CW    = $clog2(COLS),
  parameter int unsigned BW    = $clog2(BANKS),
  parameter int unsigned AW    = $clog2(COLS * BANKS)
) (
  input  logic [CW-1:0] col,
  input  logic [BW-1:0] bank,
  output logic [AW-1:0] lin
);

  localparam logic [AW-1:0] STRIDE = AW'(COLS);

  logic [AW-1:0] bank_base;

  assign bank_base = AW'(bank) * STRIDE;
  assign lin       = bank_base + AW'(col);

endmodule

// File: rtl/dptr_ram.sv
module dptr_ram #(
  parameter int unsigned DEPTH = 504,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/disp_wr_pointer.sv
module disp_wr_pointer
  import dptr_pkg::*;
#(
  parameter int unsigned COLS  = 84,
  parameter int unsigned BANKS = 6,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = $clog2(COLS),
  parameter int unsigned BW    = $clog2(BANKS),
  parameter int unsigned AW    = $clog2(COLS * BANKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          col_ld,
  input  logic [CW-1:0] col_val,
  input  logic          bank_ld,
  input  logic [BW-1:0] bank_val,
  input  logic          mode_ld,
  input  logic          mode_val,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] cur_col,
  output logic [BW-1:0] cur_bank,
  output logic          scan_mode,
  output logic [AW-1:0] lin_addr,
  output logic          mem_we
);

  localparam int unsigned DEPTH = COLS * BANKS;

  scan_mode_e    mode_q;
  logic [CW-1:0] nxt_col;
  logic [BW-1:0] nxt_bank;

  assign mem_we    = wr_en & ~rst;
  assign scan_mode = mode_q;

  dptr_next #(.COLS(COLS), .BANKS(BANKS), .CW(CW), .BW(BW)) u_next (
    .col      (cur_col),
    .bank     (cur_bank),
    .mode     (mode_q),
    .nxt_col  (nxt_col),
    .nxt_bank (nxt_bank)
  );

  dptr_regs #(.COLS(COLS), .BANKS(BANKS), .CW(CW), .BW(BW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .adv      (wr_en),
    .nxt_col  (nxt_col),
    .nxt_bank (nxt_bank),
    .col_ld   (col_ld),
    .col_val  (col_val),
    .bank_ld  (bank_ld),
    .bank_val (bank_val),
    .mode_ld  (mode_ld),
    .mode_val (scan_mode_e'(mode_val)),
    .col      (cur_col),
    .bank     (cur_bank),
    .mode     (mode_q)
  );

  dptr_linear #(.COLS(COLS), .BANKS(BANKS), .CW(CW), .BW(BW), .AW(AW)) u_lin (
    .col  (cur_col),
    .bank (cur_bank),
    .lin  (lin_addr)
  );

  dptr_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (lin_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  p_lin_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (lin_addr < AW'(DEPTH)));

  p_mode_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (!mode_ld) |=> $stable(scan_mode));

endmodule

// File: tb/disp_wr_pointer_tb.sv
module disp_wr_pointer_tb;

  localparam int COLS = 84;
  localparam int BANKS = 6;
  localparam int CELLS = COLS * BANKS;

  logic       clk = 1'b0;
  logic       rst;
  logic       col_ld, bank_ld, mode_ld, mode_val, wr_en;
  logic [6:0] col_val;
  logic [2:0] bank_val;
  logic [7:0] wr_data;
  logic [8:0] rd_addr;
  logic [7:0] rd_data;
  logic [6:0] cur_col;
  logic [2:0] cur_bank;
  logic       scan_mode;
  logic [8:0] lin_addr;
  logic       mem_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_col, m_bank, m_mode;

  disp_wr_pointer u_dut (
    .clk(clk), .rst(rst), .col_ld(col_ld), .col_val(col_val),
    .bank_ld(bank_ld), .bank_val(bank_val), .mode_ld(mode_ld),
    .mode_val(mode_val), .wr_en(wr_en), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cur_col(cur_col),
    .cur_bank(cur_bank), .scan_mode(scan_mode), .lin_addr(lin_addr),
    .mem_we(mem_we)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    col_ld = 0; bank_ld = 0; mode_ld = 0; wr_en = 0;
  endtask

  // Next position from arithmetic over the scan index
  task automatic model_adv();
    int idx;
    if (m_mode == 0) begin
      idx = (m_bank * COLS + m_col + 1) % CELLS;
      m_col = idx % COLS; m_bank = idx / COLS;
    end else begin
      idx = (m_col * BANKS + m_bank + 1) % CELLS;
      m_col = idx / BANKS; m_bank = idx % BANKS;
    end
  endtask

  task automatic check_ptr(input string req);
    check(req, int'(cur_col), m_col);
    check(req, int'(cur_bank), m_bank);
    check({req, "/R10"}, int'(lin_addr), m_bank * COLS + m_col);
  endtask

  task automatic sweep(input int mode, input int mul, input int add);
    for (int i = 0; i < CELLS; i++) begin
      wr_en = 1; wr_data = 8'((i * mul + add) & 255);
      #1;
      check("R12", int'(mem_we), 1);
      tick();
      model_adv();
      if (mode == 0) check_ptr("R3"); else check_ptr("R4");
    end
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    col_val = 0; bank_val = 0; mode_val = 0; wr_data = 0; rd_addr = 0;
    rst = 1;
    tick(); tick();
    // R1 reset state
    m_col = 0; m_bank = 0; m_mode = 0;
    check("R1", int'(cur_col), 0);
    check("R1", int'(cur_bank), 0);
    check("R1", int'(scan_mode), 0);
    wr_en = 1; #1;
    check("R12", int'(mem_we), 0);
    wr_en = 0;
    rst = 0;
    tick();

    // R3/R5 horizontal traversal over every cell, back to origin
    sweep(0, 7, 3);
    check("R5", int'(cur_col) + int'(cur_bank), 0);
    for (int a = 0; a < CELLS; a++) begin
      rd_addr = 9'(a); tick();
      check("R11", int'(rd_data), (a * 7 + 3) & 255);
    end

    // R9 mode change does not move the pointer
    col_val = 7'd10; col_ld = 1; tick(); col_ld = 0;
    m_col = 10;
    mode_val = 1; mode_ld = 1; tick(); mode_ld = 0;
    check("R9", int'(scan_mode), 1);
    check_ptr("R9");
    col_val = 0; col_ld = 1; tick(); col_ld = 0;
    m_col = 0; m_mode = 1;

    // R4/R5 vertical traversal
    sweep(1, 13, 5);
    check("R5", int'(cur_col) + int'(cur_bank), 0);
    for (int a = 0; a < CELLS; a++) begin
      int i;
      i = (a % COLS) * BANKS + (a / COLS);
      rd_addr = 9'(a); tick();
      check("R11", int'(rd_data), (i * 13 + 5) & 255);
    end

    // R6 column load over full input range, bank untouched
    bank_val = 3'd2; bank_ld = 1; tick(); bank_ld = 0;
    for (int v = 0; v < 128; v++) begin
      col_val = 7'(v); col_ld = 1; tick(); col_ld = 0;
      check("R6", int'(cur_col), (v > 83) ? 83 : v);
      check("R6", int'(cur_bank), 2);
    end
    m_col = 83;
    // R7 bank load over full input range, column untouched
    for (int v = 0; v < 8; v++) begin
      bank_val = 3'(v); bank_ld = 1; tick(); bank_ld = 0;
      check("R7", int'(cur_bank), (v > 5) ? 5 : v);
      check("R7", int'(cur_col), 83);
    end
    m_bank = 5;
    check("R2", int'(lin_addr), 5 * COLS + 83);

    // R8 column load with a write in vertical order: bank advances
    col_val = 7'd20; bank_val = 3'd3; bank_ld = 1; col_ld = 1; tick(); bank_ld = 0;
    col_val = 7'd40; col_ld = 1; wr_en = 1; wr_data = 8'hA5; tick();
    col_ld = 0; wr_en = 0;
    check("R8", int'(cur_col), 40);
    check("R8", int'(cur_bank), 4);
    rd_addr = 9'(3 * COLS + 20); tick();
    check("R11", int'(rd_data), 8'hA5);

    // R8 bank load with a write in horizontal order at column end
    mode_val = 0; mode_ld = 1; tick(); mode_ld = 0;
    col_val = 7'd83; col_ld = 1; tick(); col_ld = 0;
    bank_val = 3'd1; bank_ld = 1; wr_en = 1; tick();
    bank_ld = 0; wr_en = 0;
    check("R8", int'(cur_col), 0);
    check("R8", int'(cur_bank), 1);

    // R9 write in the same cycle as a mode change uses the old order
    col_val = 7'd5; col_ld = 1; bank_val = 3'd2; bank_ld = 1; tick();
    col_ld = 0; bank_ld = 0;
    mode_val = 1; mode_ld = 1; wr_en = 1; tick();
    mode_ld = 0;
    check("R9", int'(cur_col), 6);
    check("R9", int'(cur_bank), 2);
    tick(); wr_en = 0;
    check("R9", int'(cur_col), 6);
    check("R9", int'(cur_bank), 3);

    // R5 corner wrap in vertical order from the last cell
    col_val = 7'd83; col_ld = 1; bank_val = 3'd5; bank_ld = 1; tick();
    col_ld = 0; bank_ld = 0;
    wr_en = 1; tick(); wr_en = 0;
    check("R5", int'(cur_col), 0);
    check("R5", int'(cur_bank), 0);

    // R1 reset again from a non-origin state
    col_val = 7'd30; col_ld = 1; tick(); col_ld = 0;
    rst = 1; tick(); rst = 0;
    check("R1", int'(cur_col), 0);
    check("R1", int'(scan_mode), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule